// File: doc/BRIEF.md
# Descriptor-Driven Configuration Copy Engine

The block copies the bytes of one configuration item into system memory under control of an in-memory command record. Software arms it through a small write-only doorbell: it places a 64-bit record address there, and the write of the lower half, or one full 64-bit write, starts the work. The engine then reads the 16-byte record over a single memory master port. The record carries a command word, a byte count and a destination address. The engine may switch to a different item, then either copies bytes to the destination or advances past them. At the end it stores a completion word over the command word of the record.

Item contents sit in a small computed ROM. Each item has its own length, and a cursor remembers how far into the selected item earlier transfers have gone. Bytes requested past the end of an item, or from an item that does not exist, arrive as zeros. Key 0 is a capability item that tells software whether the copy path is present.

Top module: `cfgdma_engine`

## Requirements
- R1: The doorbell decodes writes by offset and size in bytes, and `db_wdata` carries the numeric big-endian value. A 4-byte write at offset 0 loads address bits 63:32 from `db_wdata[31:0]` and clears bits 31:0. A 4-byte write at offset 4 ORs `db_wdata[31:0]` into bits 31:0 and starts a transfer. An 8-byte write at offset 0 takes the whole address and starts a transfer. Every other offset and size combination has no effect.
- R2: When a transfer starts, the held doorbell address returns to zero. A later lone 4-byte write at offset 4 therefore starts a transfer whose record address has zero upper bits.
- R3: `busy` rises in the cycle after the starting write and falls after the completion word is accepted. While it is high, every doorbell write is ignored, including upper-half loads. Each memory request keeps its address and data steady until `mem_ready`.
- R4: The record is read as four 4-byte reads at the record address plus 0, 4, 8 and 12, with `mem_word` high. Each returned word is big-endian. In order, the words are the command word, the byte count, destination bits 63:32 and destination bits 31:0.
- R5: In the command word, bit 1 requests a copy, bit 2 requests a skip and bit 3 requests a selection. When bit 3 is set, bits 31:16 become the item key and the item cursor restarts at 0. Bit 0 and the remaining bits have no effect.
- R6: Copy wins when both bit 1 and bit 2 are set. When neither is set, the count is treated as zero: no data write occurs and the completion word is 0.
- R7: A copy issues one 1-byte write (`mem_word` low, data in `mem_wdata[7:0]`) per byte to consecutive destination addresses. Each byte taken from the item advances the cursor by one. The cursor carries over to later transfers that do not select.
- R8: An item has no data at the cursor when its key is 6 or more, when it is empty, or when the cursor is at or past its length. A copy writes zero bytes in that case. A skip issues no data writes and advances the cursor by the smaller of the count and the bytes left in the item.
- R9: When a data write returns `mem_err`, the loop stops after that beat and the completion word is 1. Bytes written before the failure stay in memory, and the cursor does not count the failed byte.
- R10: When a record read returns `mem_err`, no further reads or data writes occur. The engine writes the completion word 1 to the record address.
- R11: Every transfer ends with exactly one 4-byte write to the record address. Its value is 0 on success and 1 (bit 0) on failure.
- R12: Item 0 is 4 bytes long and holds a big-endian 32-bit value with bit 0 set. Bit 1 of that value equals parameter `DMA_EN`.
- R13: After reset, `busy` and `mem_req` are low, key 0 is selected and the cursor is 0. Item k from 1 to 5 is (k-1)*3 bytes long, and its byte at offset o is (37*k + o) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| db_wr | input | 1 | Doorbell write strobe |
| db_off | input | 3 | Doorbell byte offset |
| db_size | input | 4 | Doorbell access size in bytes |
| db_wdata | input | 64 | Doorbell write value |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_word | output | 1 | 4-byte access when high, 1-byte access when low |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Write data, big-endian word or byte in bits 7:0 |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, big-endian word |
| mem_err | input | 1 | Error response, valid with mem_ready |

## Verification
A wrong cursor does not show up in the transfer that corrupts it. It shows up in the next transfer that copies without selecting, whose bytes come from the wrong offset. Chained copy, skip and error-abort transfers therefore expose it within one extra transfer. A wrong held doorbell address shows only in the address of the next record read. A lost completion or a mis-sequenced record fetch shows within the same transfer, through the completion word in memory and the read and write beat counts.

// File: rtl/cfgdma_pkg.sv
// Shared constants and types for the configuration copy engine.
// Assumes 64-bit byte addresses and 32-bit memory words.
package cfgdma_pkg;
    localparam int ADDR_W  = 64;
    localparam int WORD_W  = 32;
    localparam int KEY_W   = 16;
    localparam int LEN_W   = 32;

    // Command word bit positions (software-visible, fixed)
    localparam int CTL_ERR_BIT  = 0;
    localparam int CTL_RD_BIT   = 1;
    localparam int CTL_SKIP_BIT = 2;
    localparam int CTL_SEL_BIT  = 3;
    localparam int CTL_KEY_LSB  = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_COPY,
        S_STAT
    } eng_state_t;
endpackage

// File: rtl/cfgdma_doorbell.sv
// Doorbell decode: collects a 64-bit record address from a full write or
// two 32-bit halves and raises a start strobe. Assumes the strobe is
// consumed in the same cycle whenever busy_i is low.
module cfgdma_doorbell
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [2:0]        off_i,
    input  logic [3:0]        size_i,
    input  logic [ADDR_W-1:0] wdata_i,
    input  logic              busy_i,
    output logic              trig_o,
    output logic [ADDR_W-1:0] trig_addr_o
);
    localparam int HALF = ADDR_W / 2;

    logic [ADDR_W-1:0] addr_q;
    logic hi_wr, lo_wr, full_wr;

    // Classify the incoming write by offset and size
    always_comb begin
        hi_wr   = wr_i && !busy_i && (off_i == 3'd0) && (size_i == 4'd4);
        lo_wr   = wr_i && !busy_i && (off_i == 3'd4) && (size_i == 4'd4);
        full_wr = wr_i && !busy_i && (off_i == 3'd0) && (size_i == 4'd8);
        trig_o  = lo_wr || full_wr;
        trig_addr_o = full_wr ? wdata_i
                              : (addr_q | {{HALF{1'b0}}, wdata_i[HALF-1:0]});
    end

    // Hold the pending address; clear it once a transfer is launched
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (hi_wr)   addr_q <= {wdata_i[HALF-1:0], {HALF{1'b0}}};
        else if (trig_o)  addr_q <= '0;
    end

    // R2
    addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> (addr_q == '0));

    // R1
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> (addr_q[HALF-1:0] == '0));
endmodule

// File: rtl/cfgdma_item_rom.sv
// Computed item store: returns length, a no-data flag and the byte at a
// given cursor for the selected key. Purely combinational; key 0 is the
// capability item, keys 1..NUM_ITEMS-1 hold a computed byte pattern.
module cfgdma_item_rom
    import cfgdma_pkg::*;
#(
    parameter int unsigned NUM_ITEMS = 6,
    parameter int unsigned LEN_STEP  = 3,
    parameter bit          DMA_EN    = 1'b1
)
(
    input  logic [KEY_W-1:0] key_i,
    input  logic [LEN_W-1:0] off_i,
    output logic [LEN_W-1:0] len_o,
    output logic             nodata_o,
    output logic [7:0]       byte_o
);
    localparam logic [LEN_W-1:0] CAP_LEN  = 32'd4;
    localparam logic [7:0]       CAP_BYTE = {6'b0, DMA_EN, 1'b1};

    logic       is_cap, valid;
    logic [7:0] mix;

    // Derive item length, availability and the addressed byte
    always_comb begin
        is_cap   = (key_i == '0);
        valid    = (32'(key_i) < NUM_ITEMS);
        len_o    = !valid ? '0
                 : is_cap ? CAP_LEN
                 : 32'((32'(key_i) - 32'd1) * LEN_STEP);
        nodata_o = !valid || (off_i >= len_o);
        mix      = key_i[7:0] * 8'd37 + off_i[7:0];
        byte_o   = is_cap ? ((off_i == 32'd3) ? CAP_BYTE : 8'h00) : mix;
    end
endmodule

// File: rtl/cfgdma_seq.sv
// Transfer sequencer: fetches the 16-byte record, applies the selection,
// runs the copy or skip loop against the item store and writes the
// completion word. Assumes a memory slave that holds mem_ready for one
// cycle per accepted beat.
module cfgdma_seq
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [ADDR_W-1:0] trig_addr_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_word_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_err_i,
    output logic [KEY_W-1:0]  key_o,
    output logic [LEN_W-1:0]  off_o,
    input  logic [LEN_W-1:0]  rom_len_i,
    input  logic              rom_nodata_i,
    input  logic [7:0]        rom_byte_i
);
    eng_state_t        st_q;
    logic [1:0]        beat_q;
    logic [ADDR_W-1:0] base_q, dst_q;
    logic [LEN_W-1:0]  rem_q, off_q;
    logic [KEY_W-1:0]  key_q, selkey_q;
    logic              sel_q, rd_q, sk_q, err_q;
    logic [LEN_W-1:0]  avail, chunk;

    assign busy_o = (st_q != S_IDLE);
    assign key_o  = key_q;
    assign off_o  = off_q;

    // Bytes a skip may consume from the current item
    always_comb begin
        avail = rom_nodata_i ? '0 : (rom_len_i - off_q);
        chunk = (rem_q < avail) ? rem_q : avail;
    end

    // Drive the memory request for the current state
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_word_o  = 1'b1;
        mem_addr_o  = base_q;
        mem_wdata_o = '0;
        case (st_q)
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = base_q + 64'({beat_q, 2'b00});
            end
            S_COPY: begin
                if (rd_q && (rem_q != '0)) begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    mem_word_o  = 1'b0;
                    mem_addr_o  = dst_q;
                    mem_wdata_o = {24'b0, rom_nodata_i ? 8'h00 : rom_byte_i};
                end
            end
            S_STAT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = 32'(err_q) << CTL_ERR_BIT;
            end
            default: ;
        endcase
    end

    // Sequence state, record fields, cursor and loop counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            beat_q   <= '0;
            base_q   <= '0;
            dst_q    <= '0;
            rem_q    <= '0;
            off_q    <= '0;
            key_q    <= '0;
            selkey_q <= '0;
            sel_q    <= 1'b0;
            rd_q     <= 1'b0;
            sk_q     <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (trig_i) begin
                        base_q <= trig_addr_i;
                        beat_q <= '0;
                        err_q  <= 1'b0;
                        st_q   <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (mem_ready_i) begin
                        if (mem_err_i) begin
                            err_q <= 1'b1;
                            st_q  <= S_STAT;
                        end else begin
                            beat_q <= beat_q + 2'd1;
                            case (beat_q)
                                2'd0: begin
                                    selkey_q <= mem_rdata_i[CTL_KEY_LSB +: KEY_W];
                                    sel_q    <= mem_rdata_i[CTL_SEL_BIT];
                                    rd_q     <= mem_rdata_i[CTL_RD_BIT];
                                    sk_q     <= mem_rdata_i[CTL_SKIP_BIT]
                                                && !mem_rdata_i[CTL_RD_BIT];
                                end
                                2'd1: rem_q <= mem_rdata_i;
                                2'd2: dst_q[ADDR_W-1:WORD_W] <= mem_rdata_i;
                                default: begin
                                    dst_q[WORD_W-1:0] <= mem_rdata_i;
                                    st_q <= S_DECODE;
                                end
                            endcase
                        end
                    end
                end
                S_DECODE: begin
                    if (sel_q) begin
                        key_q <= selkey_q;
                        off_q <= '0;
                    end
                    if (!rd_q && !sk_q) rem_q <= '0;
                    st_q <= S_COPY;
                end
                S_COPY: begin
                    if (rem_q == '0) begin
                        st_q <= S_STAT;
                    end else if (rd_q) begin
                        if (mem_ready_i) begin
                            if (mem_err_i) begin
                                err_q <= 1'b1;
                                st_q  <= S_STAT;
                            end else begin
                                dst_q <= dst_q + 64'd1;
                                rem_q <= rem_q - 32'd1;
                                if (!rom_nodata_i) off_q <= off_q + 32'd1;
                            end
                        end
                    end else begin
                        off_q <= off_q + chunk;
                        dst_q <= dst_q + 64'(rem_q);
                        rem_q <= '0;
                    end
                end
                S_STAT: begin
                    if (mem_ready_i) begin
                        err_q <= 1'b0;
                        st_q  <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && st_q == S_IDLE) |=> (st_q == S_FETCH));

    // R6
    rem_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_COPY) |=> (rem_q <= $past(rem_q)));

    // R9
    wr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_COPY && mem_req_o && mem_ready_i && mem_err_i) |=>
            (st_q == S_STAT && err_q));

    // R10
    fetch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_FETCH && mem_ready_i && mem_err_i) |=>
            (st_q == S_STAT && err_q));

    // R11
    stat_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_word_o) |->
            (mem_wdata_o[WORD_W-1:1] == '0 && mem_addr_o == base_q));
endmodule

// File: rtl/cfgdma_engine.sv
// Top of the configuration copy engine: doorbell decode, transfer
// sequencer and computed item store. Assumes one outstanding memory beat.
module cfgdma_engine
    import cfgdma_pkg::*;
#(
    parameter int unsigned NUM_ITEMS = 6,
    parameter int unsigned LEN_STEP  = 3,
    parameter bit          DMA_EN    = 1'b1
)
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        db_wr,
    input  logic [2:0]  db_off,
    input  logic [3:0]  db_size,
    input  logic [63:0] db_wdata,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_word,
    output logic [63:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err
);
    logic              trig;
    logic [ADDR_W-1:0] trig_addr;
    logic [KEY_W-1:0]  key;
    logic [LEN_W-1:0]  off, rom_len;
    logic              rom_nodata;
    logic [7:0]        rom_byte;

    cfgdma_doorbell u_db (
        .clk(clk), .rst_n(rst_n), .wr_i(db_wr), .off_i(db_off),
        .size_i(db_size), .wdata_i(db_wdata), .busy_i(busy),
        .trig_o(trig), .trig_addr_o(trig_addr)
    );

    cfgdma_seq u_seq (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .trig_addr_i(trig_addr),
        .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_word_o(mem_word), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
        .key_o(key), .off_o(off), .rom_len_i(rom_len),
        .rom_nodata_i(rom_nodata), .rom_byte_i(rom_byte)
    );

    cfgdma_item_rom #(
        .NUM_ITEMS(NUM_ITEMS), .LEN_STEP(LEN_STEP), .DMA_EN(DMA_EN)
    ) u_rom (
        .key_i(key), .off_i(off), .len_o(rom_len),
        .nodata_o(rom_nodata), .byte_o(rom_byte)
    );
endmodule

// File: tb/cfgdma_engine_tb_top.sv
module cfgdma_engine_tb_top;
    localparam int NITEMS = 6;
    localparam int STEP   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        db_wr = 1'b0;
    logic [2:0]  db_off = '0;
    logic [3:0]  db_size = '0;
    logic [63:0] db_wdata = '0;
    logic        busy, mem_req, mem_we, mem_word;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    always #10 clk = ~clk;

    cfgdma_engine #(.NUM_ITEMS(NITEMS), .LEN_STEP(STEP), .DMA_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .db_wr(db_wr), .db_off(db_off),
        .db_size(db_size), .db_wdata(db_wdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    // ---------------- memory model ----------------
    logic [7:0]  mem [0:4095];
    logic        poke_en = 1'b0;
    logic [11:0] poke_a = '0;
    logic [7:0]  poke_d = '0;
    int          rd_cnt = 0, wr_cnt = 0, wait_cnt = 0;
    logic [63:0] rd_log [0:255];
    logic [63:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    logic [11:0] ai;
    logic        bad;

    always @(posedge clk) begin
        mem_ready <= 1'b0;
        mem_err   <= 1'b0;
        if (poke_en) mem[poke_a] <= poke_d;
        if (rst_n && mem_req && !mem_ready) begin
            if (wait_cnt > 0) wait_cnt <= wait_cnt - 1;
            else begin
                ai  = mem_addr[11:0];
                bad = (mem_addr[11:10] == 2'b11);
                mem_ready <= 1'b1;
                mem_err   <= bad;
                wait_cnt  <= int'($urandom % 3);
                if (mem_we) begin
                    wr_cnt <= wr_cnt + 1;
                    last_wr_addr <= mem_addr;
                    last_wr_data <= mem_wdata;
                    if (!bad) begin
                        if (mem_word) begin
                            mem[ai]       <= mem_wdata[31:24];
                            mem[ai+12'd1] <= mem_wdata[23:16];
                            mem[ai+12'd2] <= mem_wdata[15:8];
                            mem[ai+12'd3] <= mem_wdata[7:0];
                        end else mem[ai] <= mem_wdata[7:0];
                    end
                end else begin
                    rd_log[rd_cnt[7:0]] <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                    mem_rdata <= {mem[ai], mem[ai+12'd1], mem[ai+12'd2], mem[ai+12'd3]};
                end
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int checks = 0, fails = 0;
    int m_key = 0, m_off = 0;
    int unsigned seed_v;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ilen(input int k);
        if (k >= NITEMS) return 0;
        if (k == 0) return 4;
        return (k - 1) * STEP;
    endfunction

    function automatic logic [7:0] ibyte(input int k, input int o);
        if (k == 0) return (o == 3) ? 8'h03 : 8'h00;
        return 8'(k * 37 + o);
    endfunction

    task automatic poke(input logic [63:0] a, input logic [7:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_a = a[11:0]; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic put_word(input logic [63:0] a, input logic [31:0] w);
        poke(a, w[31:24]); poke(a + 1, w[23:16]);
        poke(a + 2, w[15:8]); poke(a + 3, w[7:0]);
    endtask

    task automatic put_desc(input logic [63:0] base, input bit sel, input int key,
                            input bit rdf, input bit skf, input int len,
                            input logic [63:0] dest);
        put_word(base, {16'(key), 12'b0, sel, skf, rdf, 1'b0});
        put_word(base + 4, 32'(len));
        put_word(base + 8, dest[63:32]);
        put_word(base + 12, dest[31:0]);
    endtask

    task automatic db_write(input logic [2:0] off, input logic [3:0] size, input logic [63:0] d);
        @(negedge clk);
        db_wr = 1'b1; db_off = off; db_size = size; db_wdata = d;
        @(negedge clk);
        db_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 3000) begin @(negedge clk); n++; end
        if (busy) chk("R3 timeout", 1, 0);
    endtask

    // Full transfer with independent expected model
    task automatic run_xfer(input string tag, input logic [63:0] base, input bit sel,
                            input int key, input bit rdf, input bit skf,
                            input int len, input logic [63:0] dest);
        logic [7:0] expb [0:63];
        int rd0, wr0, beats, nwr, avail;
        logic [31:0] st_exp, st_act;
        put_desc(base, sel, key, rdf, skf, len, dest);
        for (int i = 0; i <= len; i++) poke(dest + 64'(i), 8'hEE);
        rd0 = rd_cnt; wr0 = wr_cnt;
        db_write(3'd0, 4'd8, base);
        wait_idle();
        if (sel) begin m_key = key; m_off = 0; end
        st_exp = 0; beats = 0; nwr = 0;
        if (rdf) begin
            for (int i = 0; i < len; i++) begin
                logic [63:0] a = dest + 64'(i);
                bit nod = (m_key >= NITEMS) || (m_off >= ilen(m_key));
                beats++;
                if (a[11:10] == 2'b11) begin st_exp = 1; break; end
                expb[i] = nod ? 8'h00 : ibyte(m_key, m_off);
                nwr++;
                if (!nod) m_off++;
            end
        end else if (skf) begin
            avail = (m_key >= NITEMS || m_off >= ilen(m_key)) ? 0 : ilen(m_key) - m_off;
            m_off += (len < avail) ? len : avail;
        end
        @(negedge clk);
        st_act = {mem[base[11:0]], mem[base[11:0]+12'd1], mem[base[11:0]+12'd2], mem[base[11:0]+12'd3]};
        chk({tag, " R11 status"}, st_act, st_exp);
        chk({tag, " R4 record reads"}, rd_cnt - rd0, 4);
        chk({tag, " R6 write beats"}, wr_cnt - wr0, beats + 1);
        for (int i = 0; i < nwr; i++)
            chk({tag, " R7 byte"}, mem[dest[11:0] + 12'(i)], expb[i]);
        if (rdf && st_exp == 0) chk({tag, " R7 guard"}, mem[dest[11:0] + 12'(len)], 8'hEE);
        if (!rdf) chk({tag, " R8 untouched"}, mem[dest[11:0]], 8'hEE);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int rd0, wr0;
        seed_v = $urandom(32'd4711);
        for (int i = 0; i < 4096; i++) begin end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 reset busy", busy, 0);
        chk("R13 reset req", mem_req, 0);

        // Reset cursor: key 0 at offset 0, no select
        run_xfer("R13", 64'h100, 0, 0, 1, 0, 4, 64'h400);
        // Capability item after selection
        run_xfer("R12", 64'h110, 1, 0, 1, 0, 4, 64'h410);
        // Read past end of item 2 (3 bytes)
        run_xfer("R8", 64'h120, 1, 2, 1, 0, 6, 64'h420);
        // Cursor continues across transfers
        run_xfer("R5", 64'h130, 1, 5, 1, 0, 4, 64'h440);
        run_xfer("R7", 64'h140, 0, 0, 1, 0, 3, 64'h450);
        // Skip then read
        run_xfer("R8", 64'h150, 1, 5, 0, 1, 5, 64'h460);
        run_xfer("R7", 64'h160, 0, 0, 1, 0, 2, 64'h470);
        run_xfer("R8", 64'h170, 0, 0, 0, 1, 40, 64'h480);
        // Read wins over skip; neither moves nothing
        run_xfer("R6", 64'h180, 1, 4, 1, 1, 3, 64'h490);
        run_xfer("R6", 64'h190, 1, 3, 0, 0, 5, 64'h4A0);
        // Invalid key and empty item
        run_xfer("R8", 64'h1A0, 1, 9, 1, 0, 3, 64'h4B0);
        run_xfer("R8", 64'h1B0, 1, 1, 1, 0, 2, 64'h4C0);
        // Data write error and cursor after it
        run_xfer("R9", 64'h1C0, 1, 5, 1, 0, 5, 64'hBFE);
        run_xfer("R9", 64'h1D0, 0, 0, 1, 0, 3, 64'h4D0);

        // Record fetch error
        rd0 = rd_cnt; wr0 = wr_cnt;
        db_write(3'd0, 4'd8, 64'hC00);
        wait_idle();
        @(negedge clk);
        chk("R10 reads", rd_cnt - rd0, 1);
        chk("R10 writes", wr_cnt - wr0, 1);
        chk("R10 status addr", last_wr_addr, 64'hC00);
        chk("R10 status data", last_wr_data, 1);

        // Doorbell decode
        put_desc(64'h200, 0, 0, 0, 0, 0, 64'h500);
        rd0 = rd_cnt;
        db_write(3'd0, 4'd4, 64'h1);
        db_write(3'd4, 4'd2, 64'h200);
        db_write(3'd4, 4'd8, 64'h200);
        db_write(3'd2, 4'd4, 64'h200);
        repeat (4) @(negedge clk);
        chk("R1 no start", busy, 0);
        chk("R1 no reads", rd_cnt - rd0, 0);
        db_write(3'd4, 4'd4, 64'h200);
        chk("R3 busy after start", busy, 1);
        wait_idle();
        chk("R1 split address", rd_log[rd0[7:0]], 64'h1_0000_0200);
        put_desc(64'h240, 0, 0, 0, 0, 0, 64'h500);
        rd0 = rd_cnt;
        db_write(3'd4, 4'd4, 64'h240);
        wait_idle();
        chk("R2 cleared upper", rd_log[rd0[7:0]], 64'h240);

        // Writes while busy are ignored
        put_desc(64'h300, 1, 5, 1, 0, 12, 64'h520);
        put_desc(64'h340, 0, 0, 0, 0, 0, 64'h540);
        rd0 = rd_cnt;
        db_write(3'd0, 4'd8, 64'h300);
        db_write(3'd0, 4'd8, 64'h340);
        db_write(3'd0, 4'd4, 64'h7);
        chk("R3 busy held", busy, 1);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R3 single transfer", rd_cnt - rd0, 4);
        chk("R3 idle after", busy, 0);
        m_key = 5; m_off = 12;
        rd0 = rd_cnt;
        db_write(3'd4, 4'd4, 64'h340);
        wait_idle();
        chk("R3 upper load ignored", rd_log[rd0[7:0]], 64'h340);

        // Random transfers
        for (int n = 0; n < 24; n++) begin
            int k   = int'($urandom % (NITEMS + 2));
            int md  = int'($urandom % 4);
            int ln  = int'($urandom % 14);
            bit sl  = 1'($urandom % 2);
            logic [63:0] bs = 64'h100 + 64'(($urandom % 40) * 16);
            logic [63:0] ds = 64'h600 + 64'($urandom % 300);
            run_xfer("R7", bs, sl, k, md[0], md[1], ln, ds);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule